// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer

A programmable timer for a microcontroller-class device. An 8-bit prescaler divides the system clock and produces one tick each time it wraps. Those ticks step a 16-bit down counter, so the two stages form a single 24-bit time base. When the counter is at zero and a tick arrives, the time base expires. A two-bit mode field decides what happens on expiry:

- **Auto-reload interrupt:** the counter reloads and raises the interrupt flag each time.
- **One-shot time-out:** the flag is raised once and the timer stops itself.
- **Square wave:** a waveform pin toggles and no interrupt is raised.

Software reaches the block through a plain address / write-enable / write-data / read-data port with four word registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 run, bits 2:1 mode, bit 3 interrupt enable |
| 1 | prescale | bits 7:0 |
| 2 | reload | bits 15:0 |
| 3 | status | live count in bits 15:0 (read), sticky flag in bit 31 |

Writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `reg_addr`.

Top module: `prescaled_timer`

## Requirements
- R1: After synchronous reset all four registers read zero, and `irq` and `wave` are low.
- R2: With prescale P and reload L loaded while stopped, the first expiry sets the flag (L+1)*(P+1) clock edges after the edge that sets run; a prescale of P divides the clock by P+1.
- R3: In mode 0 (mode 3 behaves the same) the counter reloads L on expiry and keeps running, so every later expiry follows the previous one by (L+1)*(P+1) edges and sets the flag again.
- R4: In mode 1 the first expiry sets the flag, clears run (control bit 0) and leaves the count at L; no further expiry happens until software sets run again.
- R5: In mode 2 `wave` toggles on every expiry, giving a period of 2*(L+1)*(P+1) edges, and the flag is never set; in any other mode `wave` is driven low.
- R6: The flag (status bit 31) stays set until a status write with bit 31 = 1 clears it; a status write with bit 31 = 0 leaves it set.
- R7: `irq` is high exactly when the flag is set and the interrupt-enable bit (control bit 3) is 1.
- R8: A reload write while run is 0 also loads the count; while run is 1 it changes only the reload register and the count is undisturbed.
- R9: Setting run restarts the prescaler from its programmed value, so from a held count C the next expiry comes (C+1)*(P+1) edges later, whatever phase the prescaler had when stopped.
- R10: When an expiry that sets the flag and a clearing status write land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request (flag AND enable) |
| wave | output | 1 | Square-wave output |

## Verification
The two functions that can meet on one edge are the hardware setting of the sticky flag at expiry and the software clear of that flag through a status write.

The bench provokes the collision with prescale 1 and reload 2, which gives an expiry interval of six edges. It counts edges from the enabling write and times the clear so that it is sampled on exactly the sixth edge. It then reads status and expects the flag to still be set.

A second, untimed clear follows the collision and must succeed. This shows that the set really did win on that edge and that the flag is not simply stuck.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int TMR_DATA_W = 32;
    localparam int TMR_ADDR_W = 2;
    localparam int FLAG_BIT   = TMR_DATA_W - 1;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_SQUARE   = 2'd2,
        MODE_SPARE    = 2'd3
    } tmr_mode_e;

    typedef enum logic [TMR_ADDR_W-1:0] {
        REG_CTRL     = 2'd0,
        REG_PRESCALE = 2'd1,
        REG_RELOAD   = 2'd2,
        REG_STATUS   = 2'd3
    } tmr_reg_e;

    // Control word layout, LSB first: run, mode, irq_en
    typedef struct packed {
        logic      irq_en;
        tmr_mode_e mode;
        logic      run;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    // Expiry raises the flag in every mode but the square-wave one
    function automatic logic mode_sets_flag(tmr_mode_e m);
        return m != MODE_SQUARE;
    endfunction

    // Expiry halts the timer only in one-shot mode
    function automatic logic mode_halts(tmr_mode_e m);
        return m == MODE_ONESHOT;
    endfunction

    function automatic logic mode_toggles(tmr_mode_e m);
        return m == MODE_SQUARE;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == '0);

    // While stopped the stage is held at the programmed value, so that
    // enabling always starts a full prescale period.
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= presc;
        end else begin
            pre_q <= pre_q - 1'b1;
        end
    end

    // R2: a nonzero prescale value never yields back-to-back ticks
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && presc != '0) |=> !tick);

    // R9: the first cycle after run rises starts a fresh prescale period
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(run) && presc != '0) |-> !tick);

endmodule

// File: rtl/tmr_downcount.sv
`timescale 1ns/1ps
module tmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = tick && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= at_zero ? reload : count - 1'b1;
        end
    end

    // R3: expiry puts the reload value back into the count
    p_expire_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (expire && !load) |=> count == $past(reload));

    // R2: a tick on a nonzero count steps it down by one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_zero && !load) |=> count == $past(count) - 1'b1);

    // R4: no tick and no load means the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TMR_ADDR_W-1:0] reg_addr,
    input  logic                  wr_en,
    input  logic [TMR_DATA_W-1:0] wr_data,
    output logic [TMR_DATA_W-1:0] rd_data,
    input  logic                  expire,
    input  logic [CNT_W-1:0]      count,
    output tmr_ctrl_t             ctrl,
    output logic [PRE_W-1:0]      presc,
    output logic [CNT_W-1:0]      reload,
    output logic                  load_now,
    output logic                  flag
);

    logic wr_ctrl, wr_pre, wr_rel, wr_stat;
    logic clear_req, set_req;

    assign wr_ctrl   = wr_en && (reg_addr == REG_CTRL);
    assign wr_pre    = wr_en && (reg_addr == REG_PRESCALE);
    assign wr_rel    = wr_en && (reg_addr == REG_RELOAD);
    assign wr_stat   = wr_en && (reg_addr == REG_STATUS);
    assign clear_req = wr_stat && wr_data[FLAG_BIT];
    assign set_req   = expire && mode_sets_flag(ctrl.mode);
    assign load_now  = wr_rel && !ctrl.run;

    // Control: a software write takes precedence over the one-shot halt
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
        end else if (expire && mode_halts(ctrl.mode)) begin
            ctrl.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc  <= '0;
            reload <= '0;
        end else begin
            if (wr_pre) presc  <= wr_data[PRE_W-1:0];
            if (wr_rel) reload <= wr_data[CNT_W-1:0];
        end
    end

    // Sticky flag: a hardware set outranks a software clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (tmr_reg_e'(reg_addr))
            REG_CTRL:     rd_data[CTRL_W-1:0] = ctrl;
            REG_PRESCALE: rd_data[PRE_W-1:0]  = presc;
            REG_RELOAD:   rd_data[CNT_W-1:0]  = reload;
            REG_STATUS: begin
                rd_data[CNT_W-1:0] = count;
                rd_data[FLAG_BIT]  = flag;
            end
            default:      rd_data = '0;
        endcase
    end

    // R4: one-shot expiry clears run unless software rewrites control
    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl.mode == MODE_ONESHOT && !wr_ctrl) |=> !ctrl.run);

    // R10: expiry in a flag-raising mode always leaves the flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl.mode != MODE_SQUARE) |=> flag);

    // R6: without a clearing write the flag stays set
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear_req) |=> flag);

endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TMR_ADDR_W-1:0] reg_addr,
    input  logic                  wr_en,
    input  logic [TMR_DATA_W-1:0] wr_data,
    output logic [TMR_DATA_W-1:0] rd_data,
    output logic                  irq,
    output logic                  wave
);

    tmr_ctrl_t        ctrl;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             load_now, flag, tick, expire;
    logic             wave_q;

    tmr_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .expire   (expire),
        .count    (count),
        .ctrl     (ctrl),
        .presc    (presc),
        .reload   (reload),
        .load_now (load_now),
        .flag     (flag)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .presc (presc),
        .tick  (tick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load_now),
        .load_val (wr_data[CNT_W-1:0]),
        .reload   (reload),
        .count    (count),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst || !mode_toggles(ctrl.mode)) begin
            wave_q <= 1'b0;
        end else if (expire) begin
            wave_q <= !wave_q;
        end
    end

    assign wave = wave_q;
    assign irq  = flag && ctrl.irq_en;

    // R5: square-wave expiry flips the output pin
    p_wave_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl.mode == MODE_SQUARE && !(wr_en && reg_addr == REG_CTRL))
        |=> wave != $past(wave));

    // R5: outside square-wave mode the pin goes low and stays low
    p_wave_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode != MODE_SQUARE && !(wr_en && reg_addr == REG_CTRL)) |=> !wave);

    // R7: the request never appears while interrupts are disabled
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);

endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq, wave;

    always #2.5 clk = ~clk;

    prescaled_timer u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wave(wave)
    );

    localparam logic [1:0] A_CTRL = 2'd0, A_PRE = 2'd1, A_REL = 2'd2, A_STAT = 2'd3;
    localparam logic [31:0] CLR = 32'h8000_0000;

    typedef struct packed {
        logic [7:0]  pre;
        logic [15:0] rel;
        logic [1:0]  mode;
        int unsigned k;     // expected expiry interval (rel+1)*(pre+1)
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 16'd3, 2'd0, 4},
        '{8'd1, 16'd4, 2'd0, 10},
        '{8'd3, 16'd2, 2'd1, 12},
        '{8'd4, 16'd5, 2'd2, 30},
        '{8'd7, 16'd0, 2'd3, 8},
        '{8'd2, 16'd9, 2'd2, 30}
    };

    int checks = 0, errors = 0;
    int cyc = 0;
    int irq_n = 0, wave_n = 0;
    int irq_t [16];
    int wave_t [16];
    logic irq_d = 1'b0, wave_d = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (irq && !irq_d) begin
            irq_t[irq_n % 16] <= cyc;
            irq_n <= irq_n + 1;
        end
        if (wave != wave_d) begin
            wave_t[wave_n % 16] <= cyc;
            wave_n <= wave_n + 1;
        end
        irq_d  <= irq;
        wave_d <= wave;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_en = 1'b0;
        #1 d = rd_data;
    endtask

    task automatic wait_irq(int target);
        for (int i = 0; i < 5000; i++) begin
            if (irq_n >= target) break;
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_wave(int target);
        for (int i = 0; i < 5000; i++) begin
            if (wave_n >= target) break;
            @(negedge clk); #1;
        end
    endtask

    function automatic logic [31:0] cw(logic run, logic [1:0] mode, logic ie);
        return {28'd0, ie, mode, run};
    endfunction

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int base, t0, c;
        rst = 1'b1; wr_en = 1'b0; reg_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1", "register after reset", r, 0);
        end
        check("R1", "irq after reset", {31'd0, irq}, 0);
        check("R1", "wave after reset", {31'd0, wave}, 0);

        // Vector table: R2 first interval, then per-mode behaviour
        for (int v = 0; v < NV; v++) begin
            wr(A_CTRL, 0);
            wr(A_PRE, {24'd0, VECS[v].pre});
            wr(A_REL, {16'd0, VECS[v].rel});
            wr(A_STAT, CLR);
            base = irq_n;
            c = wave_n;
            wr(A_CTRL, cw(1'b1, VECS[v].mode, 1'b1));
            t0 = cyc;
            if (VECS[v].mode == 2'd2) begin
                wait_wave(c + 2);
                check("R2", "square first interval", wave_t[c % 16] - t0, VECS[v].k);
                check("R5", "square half period",
                      wave_t[(c + 1) % 16] - wave_t[c % 16], VECS[v].k);
                rd(A_STAT, r);
                check("R5", "no flag in square mode", {31'd0, r[31]}, 0);
            end else begin
                wait_irq(base + 1);
                check("R2", "first expiry interval", irq_t[base % 16] - t0, VECS[v].k);
                wr(A_STAT, CLR);
                if (VECS[v].mode == 2'd1) begin
                    rd(A_CTRL, r);
                    check("R4", "run cleared after one-shot", {31'd0, r[0]}, 0);
                    rd(A_STAT, r);
                    check("R4", "count parked at reload", {16'd0, r[15:0]}, {16'd0, VECS[v].rel});
                    repeat (3 * VECS[v].k) @(negedge clk);
                    #1 check("R4", "no second expiry", irq_n, base + 1);
                    check("R5", "wave low outside square", {31'd0, wave}, 0);
                end else begin
                    wait_irq(base + 2);
                    check("R3", "periodic reload interval",
                          irq_t[(base + 1) % 16] - irq_t[base % 16], VECS[v].k);
                end
            end
        end

        // R6 / R7: sticky flag and interrupt gating
        wr(A_CTRL, 0); wr(A_PRE, 0); wr(A_REL, 3); wr(A_STAT, CLR);
        wr(A_CTRL, cw(1'b1, 2'd0, 1'b0));
        repeat (8) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_STAT, r);
        check("R6", "flag set after expiry", {31'd0, r[31]}, 1);
        check("R7", "irq masked", {31'd0, irq}, 0);
        wr(A_STAT, 32'h7FFF_FFFF);
        rd(A_STAT, r);
        check("R6", "bit31=0 write keeps flag", {31'd0, r[31]}, 1);
        wr(A_CTRL, cw(1'b0, 2'd0, 1'b1));
        #1 check("R7", "irq when enabled", {31'd0, irq}, 1);
        wr(A_STAT, CLR);
        rd(A_STAT, r);
        check("R6", "bit31=1 write clears flag", {31'd0, r[31]}, 0);
        check("R7", "irq drops with flag", {31'd0, irq}, 0);

        // R8: reload writes while running vs stopped
        wr(A_PRE, 255); wr(A_REL, 1000);
        wr(A_CTRL, cw(1'b1, 2'd0, 1'b0));
        repeat (10) @(negedge clk);
        wr(A_REL, 5);
        rd(A_STAT, r);
        check("R8", "running count untouched", {16'd0, r[15:0]}, 1000);
        rd(A_REL, r);
        check("R8", "reload register updated", r, 5);
        wr(A_CTRL, 0);
        wr(A_REL, 7);
        rd(A_STAT, r);
        check("R8", "stopped write loads count", {16'd0, r[15:0]}, 7);

        // R9: enabling restarts the prescaler
        wr(A_PRE, 3); wr(A_REL, 20); wr(A_STAT, CLR);
        wr(A_CTRL, cw(1'b1, 2'd0, 1'b1));
        repeat (30) @(negedge clk);
        wr(A_CTRL, cw(1'b0, 2'd0, 1'b1));
        rd(A_STAT, r);
        c = int'(r[15:0]);
        base = irq_n;
        wr(A_CTRL, cw(1'b1, 2'd0, 1'b1));
        t0 = cyc;
        wait_irq(base + 1);
        check("R9", "interval from held count", irq_t[base % 16] - t0, (c + 1) * 4);

        // R10: set and clear on the same edge (interval 6)
        wr(A_CTRL, 0); wr(A_PRE, 1); wr(A_REL, 2); wr(A_STAT, CLR);
        wr(A_CTRL, cw(1'b1, 2'd0, 1'b1));
        repeat (4) @(negedge clk);
        wr(A_STAT, CLR);
        wr(A_CTRL, 0);
        rd(A_STAT, r);
        check("R10", "set beats clear", {31'd0, r[31]}, 1);
        wr(A_STAT, CLR);
        rd(A_STAT, r);
        check("R10", "later clear succeeds", {31'd0, r[31]}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule